// File: doc/BRIEF.md
# PWM Time Base with Two Action Generators

This block is one PWM time base driving two output generators. A clock prescaler sets the pace of a 16-bit counter. The counter counts up, counts down, or counts up then down between zero and a programmed period. Each time the counter enters a new value, the block checks four conditions: the value is zero, the value is the period, the value equals compare A, or the value equals compare B. Each condition that holds raises a one-clock event strobe.

Each of the two generators, A and B, owns a 12-bit action word. For every event the word gives a 2-bit code that keeps, clears, sets or toggles that generator's output level. At the two compare events the code can differ depending on whether the counter stepped up or down into the value. If several events fall on the same step, a fixed priority decides which one acts.

A sync pulse can reload the counter with a phase value. This lets several such blocks be aligned to a common reference. Configuration arrives on plain register-style inputs that are expected to stay static while the timer runs.

Top module: `pwm_tbase_gen`

## Requirements
- R1: While the timer is active, the counter advances once every (cfg_prescale+1) clocks. The prescale is 8 bits (0..255). With run set at a clock edge, the first step happens on the (cfg_prescale+1)-th edge.
- R2: cfg_mode encoding: 1 counts up, 2 counts down, 3 counts up-down, 0 freezes the counter. cfg_period holds the period length minus one. In up mode the counter goes 0,1,..,cfg_period and then wraps to 0.
- R3: In down mode, a step taken from 0 (or from above cfg_period) loads cfg_period; otherwise the counter decrements.
- R4: In up-down mode the counter turns at cfg_period and at 0. Each turn value is entered exactly once per turn. A period of 0 holds the count at 0, with both turn events on every step.
- R5: When cfg_run is low or cfg_mode is 0, the count and the prescaler hold. Raising cfg_run again resumes from the held count.
- R6: ev_zero, ev_period, ev_cmp_a and ev_cmp_b are registered one-clock strobes. They are raised in the same clock in which count_o shows the entered value: 0, cfg_period, cfg_cmp_a or cfg_cmp_b respectively. A generator level changes one clock after the strobe that caused it.
- R7: Action codes: 0 keep, 1 drive low, 2 drive high, 3 toggle. Action word bits: [1:0] zero, [3:2] period, [5:4] compare A stepping up, [7:6] compare A stepping down, [9:8] compare B stepping up, [11:10] compare B stepping down. cfg_act_a controls pwm_a and cfg_act_b controls pwm_b.
- R8: The zero and period codes apply for either direction. A compare code is chosen by the direction of the step that entered the value: up mode always uses the up code, down mode always uses the down code.
- R9: When several events coincide, only the highest present event acts, even if its code is keep. The order is period, then zero, then compare B, then compare A.
- R10: With cfg_sync_en high, a clock with sync_in high loads cfg_phase into the counter on that edge, with no event strobes, whether or not the timer runs. With cfg_sync_en low, sync_in has no effect.
- R11: After reset: count 0, direction up, both outputs low, all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | Timer run enable |
| cfg_mode | input | 2 | Counting mode (0 freeze, 1 up, 2 down, 3 up-down) |
| cfg_prescale | input | 8 | Clock divide minus one |
| cfg_period | input | 16 | Period length minus one |
| cfg_cmp_a | input | 16 | Compare value A |
| cfg_cmp_b | input | 16 | Compare value B |
| cfg_act_a | input | 12 | Action word for output A |
| cfg_act_b | input | 12 | Action word for output B |
| cfg_sync_en | input | 1 | Allows sync_in to reload the counter |
| cfg_phase | input | 16 | Count value loaded on sync |
| sync_in | input | 1 | Sync request, sampled each clock |
| pwm_a | output | 1 | Output level A |
| pwm_b | output | 1 | Output level B |
| ev_zero | output | 1 | Counter entered zero |
| ev_period | output | 1 | Counter entered the period value |
| ev_cmp_a | output | 1 | Counter entered compare A |
| ev_cmp_b | output | 1 | Counter entered compare B |
| count_o | output | 16 | Current count |

## Verification
The bench concentrates on the turn points of up-down mode. A design that lingers on a turn value for two steps would report doubled zero or period strobe counts and a shifted final count.

It also checks the down-mode reload from zero, where an off-by-one error loads the period one step late. It checks direction-dependent compare codes, which a design ignoring direction would apply on both slopes.

Coincident events are tested with period 0 and with equal compare values. Wrong priority order leaves an output at the opposite level.

Hold-and-resume and sync with the enable low are checked through count_o. A design that leaks a tick or a load would show a moved count.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_TOGGLE = 2'd3
   } act_e;

   typedef enum logic [1:0] {
      MODE_HALT = 2'd0,
      MODE_UP   = 2'd1,
      MODE_DOWN = 2'd2,
      MODE_UPDN = 2'd3
   } mode_e;

   // bit offsets of each code inside a generator action word
   localparam int ACT_W        = 2;
   localparam int OFS_ZERO     = 0;
   localparam int OFS_PERIOD   = 2;
   localparam int OFS_CMPA_UP  = 4;
   localparam int OFS_CMPA_DN  = 6;
   localparam int OFS_CMPB_UP  = 8;
   localparam int OFS_CMPB_DN  = 10;
   localparam int ACT_WORD_W   = 12;

   // event vector positions
   localparam int EV_ZERO   = 0;
   localparam int EV_PERIOD = 1;
   localparam int EV_CMPA   = 2;
   localparam int EV_CMPB   = 3;
   localparam int EV_N      = 4;

   function automatic logic apply_act(input act_e code, input logic lvl);
      case (code)
         ACT_LOW:    apply_act = 1'b0;
         ACT_HIGH:   apply_act = 1'b1;
         ACT_TOGGLE: apply_act = ~lvl;
         default:    apply_act = lvl;
      endcase
   endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] div_cnt;

   assign tick = enable && (div_cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
      end else if (enable) begin
         if (tick) div_cnt <= '0;
         else      div_cnt <= div_cnt + PSC_W'(1);
      end
   end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
   import pwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_b,
   input  logic             sync_load,
   input  logic [CNT_W-1:0] phase,
   output logic [CNT_W-1:0] cnt_q,
   output logic [EV_N-1:0]  ev_q,
   output logic             ev_down_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             dir_down_q;
   logic [CNT_W-1:0] nxt_cnt;
   logic             nxt_dir_down;
   logic             step_down;
   logic [EV_N-1:0]  hit;

   always_comb begin
      nxt_cnt      = cnt_q;
      nxt_dir_down = dir_down_q;
      step_down    = 1'b0;
      case (mode_e'(mode))
         MODE_UP: begin
            nxt_cnt      = (cnt_q >= period) ? '0 : cnt_q + ONE;
            nxt_dir_down = 1'b0;
         end
         MODE_DOWN: begin
            nxt_cnt      = (cnt_q == '0 || cnt_q > period) ? period : cnt_q - ONE;
            nxt_dir_down = 1'b1;
            step_down    = 1'b1;
         end
         MODE_UPDN: begin
            if (!dir_down_q) begin
               if (cnt_q >= period) begin
                  nxt_cnt      = (period == '0) ? '0 : period - ONE;
                  nxt_dir_down = 1'b1;
                  step_down    = 1'b1;
               end else begin
                  nxt_cnt = cnt_q + ONE;
               end
            end else begin
               if (cnt_q == '0) begin
                  nxt_cnt      = (period == '0) ? '0 : ONE;
                  nxt_dir_down = 1'b0;
               end else begin
                  nxt_cnt   = cnt_q - ONE;
                  step_down = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      hit            = '0;
      hit[EV_ZERO]   = (nxt_cnt == '0);
      hit[EV_PERIOD] = (nxt_cnt == period);
      hit[EV_CMPA]   = (nxt_cnt == cmp_a);
      hit[EV_CMPB]   = (nxt_cnt == cmp_b);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         dir_down_q <= 1'b0;
         ev_q       <= '0;
         ev_down_q  <= 1'b0;
      end else if (sync_load) begin
         cnt_q <= phase;
         ev_q  <= '0;
      end else if (tick) begin
         cnt_q      <= nxt_cnt;
         dir_down_q <= nxt_dir_down;
         ev_q       <= hit;
         ev_down_q  <= step_down;
      end else begin
         ev_q <= '0;
      end
   end
endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
   import pwm_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [EV_N-1:0]       ev,
   input  logic                  ev_down,
   input  logic [ACT_WORD_W-1:0] act_word,
   output logic                  level
);
   act_e sel_code;

   // fixed priority: period, zero, compare B, compare A
   always_comb begin
      if (ev[EV_PERIOD])
         sel_code = act_e'(act_word[OFS_PERIOD +: ACT_W]);
      else if (ev[EV_ZERO])
         sel_code = act_e'(act_word[OFS_ZERO +: ACT_W]);
      else if (ev[EV_CMPB])
         sel_code = act_e'(ev_down ? act_word[OFS_CMPB_DN +: ACT_W]
                                   : act_word[OFS_CMPB_UP +: ACT_W]);
      else if (ev[EV_CMPA])
         sel_code = act_e'(ev_down ? act_word[OFS_CMPA_DN +: ACT_W]
                                   : act_word[OFS_CMPA_UP +: ACT_W]);
      else
         sel_code = ACT_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= 1'b0;
      else        level <= apply_act(sel_code, level);
   end
endmodule

// File: rtl/pwm_tbase_gen.sv
module pwm_tbase_gen
   import pwm_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PSC_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_run,
   input  logic [1:0]            cfg_mode,
   input  logic [PSC_W-1:0]      cfg_prescale,
   input  logic [CNT_W-1:0]      cfg_period,
   input  logic [CNT_W-1:0]      cfg_cmp_a,
   input  logic [CNT_W-1:0]      cfg_cmp_b,
   input  logic [ACT_WORD_W-1:0] cfg_act_a,
   input  logic [ACT_WORD_W-1:0] cfg_act_b,
   input  logic                  cfg_sync_en,
   input  logic [CNT_W-1:0]      cfg_phase,
   input  logic                  sync_in,
   output logic                  pwm_a,
   output logic                  pwm_b,
   output logic                  ev_zero,
   output logic                  ev_period,
   output logic                  ev_cmp_a,
   output logic                  ev_cmp_b,
   output logic [CNT_W-1:0]      count_o
);
   localparam int N_GEN = 2;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pwm_tbase_gen: CNT_W must lie in 2..32");
   end
   if (PSC_W < 1 || PSC_W > 16) begin : g_bad_psc_w
      $error("pwm_tbase_gen: PSC_W must lie in 1..16");
   end

   logic                  run_active;
   logic                  tick;
   logic                  sync_load;
   logic [EV_N-1:0]       ev;
   logic                  ev_down;
   logic [ACT_WORD_W-1:0] act_words [N_GEN];
   logic [N_GEN-1:0]      levels;

   assign run_active = cfg_run && (mode_e'(cfg_mode) != MODE_HALT);
   assign sync_load  = cfg_sync_en && sync_in;

   pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (run_active),
      .div    (cfg_prescale),
      .tick   (tick)
   );

   pwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .mode      (cfg_mode),
      .period    (cfg_period),
      .cmp_a     (cfg_cmp_a),
      .cmp_b     (cfg_cmp_b),
      .sync_load (sync_load),
      .phase     (cfg_phase),
      .cnt_q     (count_o),
      .ev_q      (ev),
      .ev_down_q (ev_down)
   );

   assign act_words[0] = cfg_act_a;
   assign act_words[1] = cfg_act_b;

   for (genvar g = 0; g < N_GEN; g++) begin : g_gen
      pwm_action_gen u_act (
         .clk      (clk),
         .rst_n    (rst_n),
         .ev       (ev),
         .ev_down  (ev_down),
         .act_word (act_words[g]),
         .level    (levels[g])
      );
   end

   assign pwm_a     = levels[0];
   assign pwm_b     = levels[1];
   assign ev_zero   = ev[EV_ZERO];
   assign ev_period = ev[EV_PERIOD];
   assign ev_cmp_a  = ev[EV_CMPA];
   assign ev_cmp_b  = ev[EV_CMPB];
endmodule

// File: rtl/pwm_tbase_gen_chk.sv
module pwm_tbase_gen_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_run,
   input logic [1:0]       cfg_mode,
   input logic [CNT_W-1:0] cfg_period,
   input logic             cfg_sync_en,
   input logic [CNT_W-1:0] cfg_phase,
   input logic             sync_in,
   input logic             pwm_a,
   input logic             pwm_b,
   input logic             ev_zero,
   input logic             ev_period,
   input logic             ev_cmp_a,
   input logic             ev_cmp_b,
   input logic [CNT_W-1:0] count_o
);
   logic past_ok;
   logic any_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign any_ev = ev_zero | ev_period | ev_cmp_a | ev_cmp_b;

   assert_zero_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_zero |-> count_o == '0);

   assert_period_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ev_period) |-> count_o == $past(cfg_period));

   assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(cfg_run && cfg_mode != 2'd0) && !$past(cfg_sync_en && sync_in))
      |-> count_o == $past(count_o));

   assert_sync_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(cfg_sync_en && sync_in)) |-> (count_o == $past(cfg_phase) && !any_ev));

   assert_pwm_a_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && pwm_a != $past(pwm_a)) |-> $past(any_ev));

   assert_pwm_b_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && pwm_b != $past(pwm_b)) |-> $past(any_ev));
endmodule

bind pwm_tbase_gen pwm_tbase_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_run     (cfg_run),
   .cfg_mode    (cfg_mode),
   .cfg_period  (cfg_period),
   .cfg_sync_en (cfg_sync_en),
   .cfg_phase   (cfg_phase),
   .sync_in     (sync_in),
   .pwm_a       (pwm_a),
   .pwm_b       (pwm_b),
   .ev_zero     (ev_zero),
   .ev_period   (ev_period),
   .ev_cmp_a    (ev_cmp_a),
   .ev_cmp_b    (ev_cmp_b),
   .count_o     (count_o)
);

// File: tb/sim_pwm_tbase_gen.sv
`timescale 1ns/1ps
module sim_pwm_tbase_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_run = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic [7:0]  cfg_prescale = 8'd0;
   logic [15:0] cfg_period = 16'd0;
   logic [15:0] cfg_cmp_a = 16'd0;
   logic [15:0] cfg_cmp_b = 16'd0;
   logic [11:0] cfg_act_a = 12'd0;
   logic [11:0] cfg_act_b = 12'd0;
   logic        cfg_sync_en = 1'b0;
   logic [15:0] cfg_phase = 16'd0;
   logic        sync_in = 1'b0;
   logic        pwm_a, pwm_b, ev_zero, ev_period, ev_cmp_a, ev_cmp_b;
   logic [15:0] count_o;

   always #2 clk = ~clk;

   pwm_tbase_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_mode(cfg_mode),
      .cfg_prescale(cfg_prescale), .cfg_period(cfg_period),
      .cfg_cmp_a(cfg_cmp_a), .cfg_cmp_b(cfg_cmp_b),
      .cfg_act_a(cfg_act_a), .cfg_act_b(cfg_act_b),
      .cfg_sync_en(cfg_sync_en), .cfg_phase(cfg_phase), .sync_in(sync_in),
      .pwm_a(pwm_a), .pwm_b(pwm_b), .ev_zero(ev_zero), .ev_period(ev_period),
      .ev_cmp_a(ev_cmp_a), .ev_cmp_b(ev_cmp_b), .count_o(count_o)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic [15:0] period;
      logic [7:0]  psc;
      logic [15:0] cmpa;
      logic [15:0] cmpb;
      logic [11:0] acta;
      logic [11:0] actb;
      logic [15:0] ncyc;
      logic [15:0] exp_cnt;
      logic        exp_a;
      logic        exp_b;
      logic [7:0]  exp_nz;
      logic [7:0]  exp_np;
   } vec_t;

   // R2 up, R1 prescale, R3 down, R4 up-down, R9 priority, R5 frozen, R4/R9 period zero
   localparam vec_t VECS [7] = '{
      '{2'd1, 16'd9, 8'd0, 16'd3, 16'd0, 12'h012, 12'h00C, 16'd22, 16'd2, 1'b1, 1'b0, 8'd2, 8'd2},
      '{2'd1, 16'd9, 8'd2, 16'd3, 16'd0, 12'h012, 12'h00C, 16'd64, 16'd1, 1'b1, 1'b0, 8'd2, 8'd2},
      '{2'd2, 16'd9, 8'd0, 16'd4, 16'd0, 12'h084, 12'h003, 16'd27, 16'd3, 1'b1, 1'b0, 8'd2, 8'd3},
      '{2'd3, 16'd4, 8'd0, 16'd2, 16'd1, 12'h060, 12'h300, 16'd19, 16'd3, 1'b1, 1'b1, 8'd2, 8'd2},
      '{2'd1, 16'd3, 8'd0, 16'd3, 16'd3, 12'h318, 12'h120, 16'd3,  16'd3, 1'b1, 1'b0, 8'd0, 8'd1},
      '{2'd0, 16'd9, 8'd0, 16'd3, 16'd0, 12'h012, 12'h00C, 16'd10, 16'd0, 1'b0, 1'b0, 8'd0, 8'd0},
      '{2'd3, 16'd0, 8'd0, 16'd5, 16'd5, 12'h006, 12'h003, 16'd4,  16'd0, 1'b0, 1'b0, 8'd4, 8'd4}
   };

   int n_chk = 0;
   int n_bad = 0;
   int nz, np;
   bit done = 1'b0;

   task automatic check(input string req, input int act, input int exp_v, input string what);
      n_chk++;
      if (act != exp_v) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (ev_zero)   nz++;
         if (ev_period) np++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cfg_run = 1'b0;
      sync_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // reset state R11
      do_reset();
      check("R11", count_o, 0, "count after reset");
      check("R11", pwm_a, 0, "pwm_a after reset");
      check("R11", pwm_b, 0, "pwm_b after reset");
      check("R11", ev_zero | ev_period | ev_cmp_a | ev_cmp_b, 0, "strobes after reset");

      // table walk
      for (int v = 0; v < 7; v++) begin
         cfg_mode     = VECS[v].mode;
         cfg_period   = VECS[v].period;
         cfg_prescale = VECS[v].psc;
         cfg_cmp_a    = VECS[v].cmpa;
         cfg_cmp_b    = VECS[v].cmpb;
         cfg_act_a    = VECS[v].acta;
         cfg_act_b    = VECS[v].actb;
         cfg_sync_en  = 1'b0;
         do_reset();
         nz = 0; np = 0;
         cfg_run = 1'b1;
         edges(int'(VECS[v].ncyc));
         cfg_run = 1'b0;
         edges(1);
         check("R2", count_o, int'(VECS[v].exp_cnt), $sformatf("vec%0d count", v));
         check("R7", pwm_a, int'(VECS[v].exp_a), $sformatf("vec%0d pwm_a (R8 R9)", v));
         check("R7", pwm_b, int'(VECS[v].exp_b), $sformatf("vec%0d pwm_b (R8 R9)", v));
         check("R6", nz, int'(VECS[v].exp_nz), $sformatf("vec%0d zero strobes (R4)", v));
         check("R6", np, int'(VECS[v].exp_np), $sformatf("vec%0d period strobes (R3)", v));
      end

      // directed: stop holds, resume continues (R5)
      cfg_mode = 2'd1; cfg_period = 16'd9; cfg_prescale = 8'd0;
      cfg_act_a = 12'h0; cfg_act_b = 12'h0; cfg_cmp_a = 16'd0; cfg_cmp_b = 16'd0;
      do_reset();
      nz = 0; np = 0;
      cfg_run = 1'b1;
      edges(5);
      check("R5", count_o, 5, "count after five steps");
      cfg_run = 1'b0;
      edges(4);
      check("R5", count_o, 5, "count held while stopped");
      cfg_run = 1'b1;
      edges(3);
      check("R5", count_o, 8, "count resumed from held value");
      cfg_run = 1'b0;
      edges(1);

      // directed: sync ignored when disabled, loads when enabled (R10)
      cfg_sync_en = 1'b0; cfg_phase = 16'd2;
      sync_in = 1'b1;
      edges(1);
      sync_in = 1'b0;
      edges(1);
      check("R10", count_o, 8, "sync with enable low has no effect");
      cfg_sync_en = 1'b1;
      sync_in = 1'b1;
      edges(1);
      sync_in = 1'b0;
      check("R10", count_o, 2, "sync loads phase");
      cfg_run = 1'b1;
      edges(3);
      check("R10", count_o, 5, "counting continues from phase");
      cfg_run = 1'b0;
      cfg_sync_en = 1'b0;
      edges(1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule